// File: doc/BRIEF.md
# PCM Serial Port Framer

This block is a synchronous serial port for time-division channel data on a PCM-style link. An external bit clock, one transmit sync and one receive sync arrive as plain inputs. They are oversampled in the faster system clock domain through a flop synchronizer. Edges of the bit clock and of each sync are found by comparing consecutive synchronized samples.

On the parallel side, a word of `WORD_W` bits is loaded with a strobe into a one-word transmit holding register. Received words come back in a one-word receive holding register. That register raises a valid flag and is emptied with a pop strobe.

A configuration bit selects the framing mode. In short-frame mode, the sync is a single-bit-period pulse one bit period ahead of the data. In long-frame mode, the sync stays high across the whole data field. In long-frame mode, the sync level also decides when the transmit line is driven and when it is released. Transmit underrun, receive overrun and framing errors are reported through two sticky flags and an error counter.

Top module: `pcm_framer`

## Requirements
- R1: After reset, `tx_oe_o` and `rx_valid_o` are 0, `tx_ready_o` is 1, both sticky flags are 0 and `err_cnt_o` is 0.
- R2: In short-frame mode (`long_mode_i`=0), the receive sync is sampled high on a bit clock falling edge. The next `WORD_W` falling edges then sample `rx_data_i`, most significant bit first, and the assembled word appears on `rx_word_o` with `rx_valid_o`=1.
- R3: In short-frame mode, the transmitter starts on the first bit clock rising edge after a falling edge that sampled the transmit sync high. From that edge it drives the `WORD_W` bits MSB first, changing on rising edges, with `tx_oe_o`=1. It releases `tx_oe_o` on the rising edge after the last bit.
- R4: In long-frame mode (`long_mode_i`=1), `rx_data_i` is sampled on each falling edge at which the receive sync is high. The first `WORD_W` such samples form the word, MSB first, and further samples while the sync stays high are ignored.
- R5: In long-frame mode, the first transmit bit is driven, with `tx_oe_o`=1, as soon as the transmit sync rises. Each later bit follows on a rising edge once the previous bit has crossed a falling edge. `tx_oe_o` drops when the transmit sync falls.
- R6: If a transmit word starts while the holding register is empty, the word sent is all ones and `tx_underrun_o` sets and stays set until reset.
- R7: If a received word completes while `rx_valid_o` is still 1 and no pop is given, the older word is kept on `rx_word_o` and `rx_overrun_o` sets and stays set until reset.
- R8: A framing error adds one to `err_cnt_o` for each lane that has it, saturating at all ones. A lane has a framing error when a short-frame sync arrives on a falling edge where a word is in progress and the bit being taken is not the last one. It also has one when a long-frame sync ends before `WORD_W` bits. On the receive side, an aborted word is never delivered.
- R9: `tx_ready_o` is 1 only while the transmit holding register is empty. A `tx_load_i` pulse while `tx_ready_o`=0 is ignored.
- R10: In short-frame mode, a sync sampled on the same falling edge as the last bit of a word starts the next word with no idle bit and no framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, more than 2.5 times the bit clock rate |
| rst_n | input | 1 | Active-low reset |
| long_mode_i | input | 1 | Framing mode: 0 short-frame, 1 long-frame |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| tx_sync_i | input | 1 | Transmit frame sync (asynchronous) |
| rx_sync_i | input | 1 | Receive frame sync (asynchronous) |
| rx_data_i | input | 1 | Serial receive data |
| tx_data_o | output | 1 | Serial transmit data, 0 while not driven |
| tx_oe_o | output | 1 | Transmit driver enable; 0 means high impedance |
| tx_word_i | input | WORD_W | Transmit word to load |
| tx_load_i | input | 1 | Load strobe for `tx_word_i` |
| tx_ready_o | output | 1 | Transmit holding register empty |
| rx_word_o | output | WORD_W | Oldest received word |
| rx_valid_o | output | 1 | `rx_word_o` holds an unread word |
| rx_pop_i | input | 1 | Consume the word on `rx_word_o` |
| tx_underrun_o | output | 1 | Sticky transmit underrun flag |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |
| err_cnt_o | output | ERR_W | Saturating framing error count |

## Verification
The hardest state to reach from the ports is a sync that lands in the middle of a word. It has to arrive on the exact falling edge where the bit being taken is not the last one. That is only possible once the bench knows its bit-cycle position relative to the synchronizer latency. The bench steps the bit clock itself, a fixed number of system clocks per half period, so it controls which falling edge sees each sync level. It then places a second short sync four bits into a word and drops a long sync after three bits. It also places a sync on the very last bit to show that back-to-back framing is not treated as an error. Random frames in both modes, with random words and random skipped loads, run alongside these directed cases.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   // Framing mode selected by the configuration input.
   typedef enum logic {
      FRM_SHORT = 1'b0,
      FRM_LONG  = 1'b1
   } frm_mode_e;

   // Asynchronous pins that cross into the system clock domain.
   typedef struct packed {
      logic bclk;
      logic tx_sync;
      logic rx_sync;
      logic rx_data;
   } pcm_pins_t;

   localparam int PINS_W = $bits(pcm_pins_t);

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_edge_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("pcm_edge_sync: W must be at least 1");
      end
   endgenerate

   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i[g]};
            last_q  <= chain_q[STAGES-1];
         end
      end

      assign q_o[g]    = chain_q[STAGES-1];
      assign rise_o[g] = chain_q[STAGES-1] & ~last_q;
      assign fall_o[g] = ~chain_q[STAGES-1] & last_q;
   end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_i,
   input  logic              b_rise_i,
   input  logic              b_fall_i,
   input  logic              sync_i,
   input  logic              sync_rise_i,
   input  logic              sync_fall_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              load_i,
   output logic              data_o,
   output logic              oe_o,
   output logic              ready_o,
   output logic              underrun_o,
   output logic              abort_o
);

   localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

   logic [WORD_W-1:0] hold_q, sh_q;
   logic              full_q, active_q, sampled_q, armed_q, under_q;
   logic [IW-1:0]     idx_q;

   logic start, shift, stop, mark, arm_set, abort;

   // Event decode for one system clock cycle.
   always_comb begin
      start   = 1'b0;
      shift   = 1'b0;
      stop    = 1'b0;
      mark    = 1'b0;
      arm_set = 1'b0;
      abort   = 1'b0;
      if (long_i) begin
         if (sync_rise_i) begin
            start = 1'b1;
         end else if (sync_fall_i) begin
            stop  = 1'b1;
            abort = active_q && !(idx_q == LAST && sampled_q);
         end else if (b_fall_i && active_q) begin
            mark = 1'b1;
         end else if (b_rise_i && active_q && sampled_q && idx_q != LAST) begin
            shift = 1'b1;
         end
      end else begin
         if (b_fall_i) begin
            mark = active_q;
            if (sync_i) begin
               arm_set = 1'b1;
               abort   = active_q && idx_q != LAST;
            end
         end else if (b_rise_i) begin
            if (armed_q) begin
               start = 1'b1;
            end else if (active_q) begin
               if (idx_q == LAST) stop = 1'b1;
               else               shift = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         sh_q      <= '0;
         full_q    <= 1'b0;
         active_q  <= 1'b0;
         sampled_q <= 1'b0;
         armed_q   <= 1'b0;
         under_q   <= 1'b0;
         idx_q     <= '0;
      end else begin
         if (start) begin
            active_q  <= 1'b1;
            idx_q     <= '0;
            sampled_q <= 1'b0;
            armed_q   <= 1'b0;
            sh_q      <= full_q ? hold_q : '1;
            if (!full_q) under_q <= 1'b1;
         end else if (stop) begin
            active_q <= 1'b0;
         end else if (shift) begin
            sh_q      <= {sh_q[WORD_W-2:0], 1'b1};
            idx_q     <= idx_q + 1'b1;
            sampled_q <= 1'b0;
         end
         if (mark)    sampled_q <= 1'b1;
         if (arm_set) armed_q   <= 1'b1;
         if (long_i && armed_q) armed_q <= 1'b0;

         if (start && full_q) begin
            full_q <= 1'b0;
         end else if (load_i && !full_q) begin
            full_q <= 1'b1;
            hold_q <= word_i;
         end
      end
   end

   assign data_o     = active_q & sh_q[WORD_W-1];
   assign oe_o       = active_q;
   assign ready_o    = ~full_q;
   assign underrun_o = under_q;
   assign abort_o    = abort;

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_i,
   input  logic              b_fall_i,
   input  logic              sync_i,
   input  logic              data_i,
   input  logic              pop_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o,
   output logic              overrun_o,
   output logic              abort_o
);

   localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

   logic [WORD_W-1:0] sh_q, sh_n, hold_q, bit_new;
   logic [IW-1:0]     cnt_q, cnt_n;
   logic              armed_q, armed_n, wait_q, wait_n;
   logic              full_q, ovr_q, full_eff;
   logic              deliver, abort;

   assign bit_new = {sh_q[WORD_W-2:0], data_i};

   always_comb begin
      sh_n    = sh_q;
      cnt_n   = cnt_q;
      armed_n = armed_q;
      wait_n  = wait_q;
      deliver = 1'b0;
      abort   = 1'b0;
      if (b_fall_i) begin
         if (long_i) begin
            armed_n = 1'b0;
            if (sync_i) begin
               if (!wait_q) begin
                  sh_n = bit_new;
                  if (cnt_q == LAST) begin
                     deliver = 1'b1;
                     wait_n  = 1'b1;
                     cnt_n   = '0;
                  end else begin
                     cnt_n = cnt_q + 1'b1;
                  end
               end
            end else begin
               abort  = (cnt_q != '0);
               cnt_n  = '0;
               wait_n = 1'b0;
            end
         end else begin
            wait_n = 1'b0;
            if (armed_q) begin
               sh_n = bit_new;
               if (cnt_q == LAST) begin
                  deliver = 1'b1;
                  armed_n = 1'b0;
                  cnt_n   = '0;
               end else begin
                  cnt_n = cnt_q + 1'b1;
               end
            end
            if (sync_i) begin
               abort   = armed_q && cnt_q != LAST;
               armed_n = 1'b1;
               cnt_n   = '0;
            end
         end
      end
   end

   assign full_eff = full_q & ~pop_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b0;
         wait_q  <= 1'b0;
         hold_q  <= '0;
         full_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         sh_q    <= sh_n;
         cnt_q   <= cnt_n;
         armed_q <= armed_n;
         wait_q  <= wait_n;
         full_q  <= deliver | full_eff;
         if (deliver && !full_eff) hold_q <= bit_new;
         if (deliver && full_eff)  ovr_q  <= 1'b1;
      end
   end

   assign word_o    = hold_q;
   assign valid_o   = full_q;
   assign overrun_o = ovr_q;
   assign abort_o   = abort;

endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
   import pcm_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ERR_W       = 8,
   parameter bit ERR_SAT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_mode_i,
   input  logic              bclk_i,
   input  logic              tx_sync_i,
   input  logic              rx_sync_i,
   input  logic              rx_data_i,
   output logic              tx_data_o,
   output logic              tx_oe_o,
   input  logic [WORD_W-1:0] tx_word_i,
   input  logic              tx_load_i,
   output logic              tx_ready_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              rx_valid_o,
   input  logic              rx_pop_i,
   output logic              tx_underrun_o,
   output logic              rx_overrun_o,
   output logic [ERR_W-1:0]  err_cnt_o
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("pcm_framer: WORD_W must be at least 2");
      end
      if (ERR_W < 2) begin : g_bad_err
         $error("pcm_framer: ERR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pcm_framer: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pcm_pins_t pins_raw, pins_q, pins_rise, pins_fall;
   logic [PINS_W-1:0] q_vec, rise_vec, fall_vec;

   assign pins_raw = '{bclk: bclk_i, tx_sync: tx_sync_i,
                       rx_sync: rx_sync_i, rx_data: rx_data_i};

   pcm_edge_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pins_raw),
      .q_o    (q_vec),
      .rise_o (rise_vec),
      .fall_o (fall_vec)
   );

   assign pins_q    = pcm_pins_t'(q_vec);
   assign pins_rise = pcm_pins_t'(rise_vec);
   assign pins_fall = pcm_pins_t'(fall_vec);

   logic unused_edges;
   assign unused_edges = ^{pins_q.bclk, pins_rise.rx_sync, pins_rise.rx_data,
                           pins_fall.rx_sync, pins_fall.rx_data};

   // Synchronized transmit sync level, observed by the bound checker.
   logic tx_sync_s;
   assign tx_sync_s = pins_q.tx_sync;

   logic tx_abort, rx_abort;

   pcm_tx_lane #(.WORD_W(WORD_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .long_i      (long_mode_i),
      .b_rise_i    (pins_rise.bclk),
      .b_fall_i    (pins_fall.bclk),
      .sync_i      (tx_sync_s),
      .sync_rise_i (pins_rise.tx_sync),
      .sync_fall_i (pins_fall.tx_sync),
      .word_i      (tx_word_i),
      .load_i      (tx_load_i),
      .data_o      (tx_data_o),
      .oe_o        (tx_oe_o),
      .ready_o     (tx_ready_o),
      .underrun_o  (tx_underrun_o),
      .abort_o     (tx_abort)
   );

   pcm_rx_lane #(.WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_i    (long_mode_i),
      .b_fall_i  (pins_fall.bclk),
      .sync_i    (pins_q.rx_sync),
      .data_i    (pins_q.rx_data),
      .pop_i     (rx_pop_i),
      .word_o    (rx_word_o),
      .valid_o   (rx_valid_o),
      .overrun_o (rx_overrun_o),
      .abort_o   (rx_abort)
   );

   // Framing error counter: both lanes may report in one cycle.
   logic [ERR_W-1:0] err_q;
   logic [ERR_W:0]   err_sum;
   assign err_sum = {1'b0, err_q} + (ERR_W+1)'(tx_abort) + (ERR_W+1)'(rx_abort);

   generate
      if (ERR_SAT) begin : g_err_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          err_q <= '0;
            else if (err_sum[ERR_W]) err_q <= '1;
            else                 err_q <= err_sum[ERR_W-1:0];
         end
      end else begin : g_err_wrap
         logic unused_carry;
         assign unused_carry = err_sum[ERR_W];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= '0;
            else        err_q <= err_sum[ERR_W-1:0];
         end
      end
   endgenerate

   assign err_cnt_o = err_q;

endmodule

// File: rtl/pcm_framer_chk.sv
module pcm_framer_chk #(
   parameter int WORD_W  = 8,
   parameter int ERR_W   = 8,
   parameter bit ERR_SAT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              long_mode_i,
   input logic              tx_sync_s,
   input logic              tx_oe_o,
   input logic [WORD_W-1:0] rx_word_o,
   input logic              rx_valid_o,
   input logic              rx_pop_i,
   input logic              tx_underrun_o,
   input logic              rx_overrun_o,
   input logic [ERR_W-1:0]  err_cnt_o
);

   // R5
   long_oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (long_mode_i && $past(long_mode_i) && !tx_sync_s) |=> !tx_oe_o);

   // R7
   rx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_o && !rx_pop_i) |=> (rx_valid_o && $stable(rx_word_o)));

   // R6
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun_o |=> tx_underrun_o);

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun_o |=> rx_overrun_o);

   generate
      if (ERR_SAT) begin : g_mono
         // R8
         err_count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (err_cnt_o >= $past(err_cnt_o)));
      end
   endgenerate

endmodule

bind pcm_framer pcm_framer_chk #(
   .WORD_W  (WORD_W),
   .ERR_W   (ERR_W),
   .ERR_SAT (ERR_SAT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .long_mode_i   (long_mode_i),
   .tx_sync_s     (tx_sync_s),
   .tx_oe_o       (tx_oe_o),
   .rx_word_o     (rx_word_o),
   .rx_valid_o    (rx_valid_o),
   .rx_pop_i      (rx_pop_i),
   .tx_underrun_o (tx_underrun_o),
   .rx_overrun_o  (rx_overrun_o),
   .err_cnt_o     (err_cnt_o)
);

// File: tb/sim_pcm_framer.sv
module sim_pcm_framer;

   localparam int W  = 8;
   localparam int EW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic long_mode = 1'b0;
   logic bclk = 1'b0, tsync = 1'b0, rsync = 1'b0, rdat = 1'b0;
   logic [W-1:0] tx_word = '0;
   logic tx_load = 1'b0, rx_pop = 1'b0;
   logic tx_data_o, tx_oe_o, tx_ready_o, rx_valid_o, tx_underrun_o, rx_overrun_o;
   logic [W-1:0] rx_word_o;
   logic [EW-1:0] err_cnt_o;

   always #5 clk = ~clk;

   pcm_framer #(.WORD_W(W), .ERR_W(EW)) u0 (
      .clk(clk), .rst_n(rst_n), .long_mode_i(long_mode),
      .bclk_i(bclk), .tx_sync_i(tsync), .rx_sync_i(rsync), .rx_data_i(rdat),
      .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o),
      .tx_word_i(tx_word), .tx_load_i(tx_load), .tx_ready_o(tx_ready_o),
      .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o), .rx_pop_i(rx_pop),
      .tx_underrun_o(tx_underrun_o), .rx_overrun_o(rx_overrun_o),
      .err_cnt_o(err_cnt_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   bit auto_pop = 1'b1;
   logic cap_d, cap_oe;
   logic [W-1:0] got [0:255];
   int got_n = 0;

   function automatic logic [W-1:0] ones_word();
      return '1;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One bit period: rising half then falling half, 6 system clocks each.
   task automatic bit_cyc(input logic ts, input logic rs, input logic rd);
      @(negedge clk);
      bclk = 1'b1; tsync = ts; rsync = rs; rdat = rd;
      if (auto_pop && rx_valid_o && got_n < 256) begin
         got[got_n] = rx_word_o;
         got_n++;
         rx_pop = 1'b1;
      end
      @(negedge clk);
      rx_pop = 1'b0;
      repeat (5) @(negedge clk);
      cap_d = tx_data_o;
      cap_oe = tx_oe_o;
      bclk = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic load(input logic [W-1:0] w);
      @(negedge clk);
      tx_word = w; tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   // Complete frame in the current mode; the caller loads the transmit word.
   task automatic frame(input logic [W-1:0] rxw, input logic [W-1:0] exp_tx,
                        input bit chk_rx, input string tag_rx, input string tag_tx);
      logic [W-1:0] cap;
      bit oe_all;
      int n0;
      cap = '0; oe_all = 1'b1; n0 = got_n;
      if (!long_mode) bit_cyc(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < W; i++) begin
         bit_cyc(long_mode, long_mode, rxw[W-1-i]);
         cap[W-1-i] = cap_d;
         oe_all &= cap_oe;
      end
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(oe_all, tag_tx, 32'(oe_all), 32'd1);
      check(cap == exp_tx, tag_tx, 32'(cap), 32'(exp_tx));
      check(!cap_oe, tag_tx, 32'(cap_oe), 32'd0);
      if (chk_rx) begin
         check(got_n == n0 + 1, tag_rx, 32'(got_n - n0), 32'd1);
         check(got[n0] == rxw, tag_rx, 32'(got[n0]), 32'(rxw));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] wa, wb, wc, wd;
      logic [W-1:0] cap;
      int e0, n0;
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      check(!tx_oe_o, "R1", 32'(tx_oe_o), 32'd0);
      check(!rx_valid_o, "R1", 32'(rx_valid_o), 32'd0);
      check(tx_ready_o, "R1", 32'(tx_ready_o), 32'd1);
      check(!tx_underrun_o && !rx_overrun_o, "R1",
            32'({tx_underrun_o, rx_overrun_o}), 32'd0);
      check(err_cnt_o == '0, "R1", 32'(err_cnt_o), 32'd0);

      // R2 / R3 short frame
      load(8'hA5);
      frame(8'h3C, 8'hA5, 1'b1, "R2", "R3");
      check(!tx_underrun_o, "R6", 32'(tx_underrun_o), 32'd0);

      // R9 second load while full is ignored
      load(8'h5A);
      check(!tx_ready_o, "R9", 32'(tx_ready_o), 32'd0);
      load(8'hFF ^ 8'h81);
      frame(8'hC3, 8'h5A, 1'b1, "R2", "R9");
      check(tx_ready_o, "R9", 32'(tx_ready_o), 32'd1);

      // R4 / R5 long frame
      long_mode = 1'b1;
      load(8'h96);
      frame(8'h71, 8'h96, 1'b1, "R4", "R5");

      // R6 underrun: no load, all ones, sticky flag
      frame(8'h0F, ones_word(), 1'b1, "R4", "R6");
      check(tx_underrun_o, "R6", 32'(tx_underrun_o), 32'd1);

      // R4 extra bits while long sync stays high are ignored
      load(8'h12);
      n0 = got_n;
      cap = '0;
      for (int i = 0; i < W; i++) begin
         bit_cyc(1'b1, 1'b1, 8'hE4 >> (W-1-i));
         cap[W-1-i] = cap_d;
      end
      bit_cyc(1'b1, 1'b1, 1'b0);
      bit_cyc(1'b1, 1'b1, 1'b1);
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(got_n == n0 + 1 && got[n0] == 8'hE4, "R4", 32'(got[n0]), 32'hE4);
      check(cap == 8'h12, "R5", 32'(cap), 32'h12);
      check(!cap_oe, "R5", 32'(cap_oe), 32'd0);

      // R8 long sync ends after three bits
      e0 = int'(err_cnt_o); n0 = got_n;
      load(8'h44);
      for (int i = 0; i < 3; i++) bit_cyc(1'b1, 1'b1, 1'b1);
      bit_cyc(1'b0, 1'b0, 1'b0);
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(int'(err_cnt_o) == e0 + 2, "R8", 32'(err_cnt_o), 32'(e0 + 2));
      check(got_n == n0, "R8", 32'(got_n - n0), 32'd0);
      check(!cap_oe, "R5", 32'(cap_oe), 32'd0);

      // R8 short sync arriving four bits into a word
      long_mode = 1'b0;
      bit_cyc(1'b0, 1'b0, 1'b0);
      e0 = int'(err_cnt_o); n0 = got_n;
      load(8'h77);
      bit_cyc(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) bit_cyc(1'b0, 1'b0, 1'b1);
      bit_cyc(1'b1, 1'b1, 1'b1);
      check(int'(err_cnt_o) == e0 + 2, "R8", 32'(err_cnt_o), 32'(e0 + 2));
      cap = '0;
      for (int i = 0; i < W; i++) begin
         bit_cyc(1'b0, 1'b0, 8'h9B >> (W-1-i));
         cap[W-1-i] = cap_d;
      end
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(got_n == n0 + 1 && got[n0] == 8'h9B, "R8", 32'(got[n0]), 32'h9B);
      check(cap == ones_word(), "R8", 32'(cap), 32'hFF);

      // R10 back-to-back short frames
      e0 = int'(err_cnt_o); n0 = got_n;
      wa = 8'hB1; wb = 8'h2E; wc = 8'h6D; wd = 8'hD8;
      load(wa);
      bit_cyc(1'b1, 1'b1, 1'b0);
      cap = '0;
      for (int i = 0; i < W; i++) begin
         bit_cyc(i == W-1, i == W-1, wc[W-1-i]);
         cap[W-1-i] = cap_d;
         if (i == 2) load(wb);
      end
      check(cap == wa, "R10", 32'(cap), 32'(wa));
      cap = '0;
      for (int i = 0; i < W; i++) begin
         bit_cyc(1'b0, 1'b0, wd[W-1-i]);
         cap[W-1-i] = cap_d;
      end
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(cap == wb, "R10", 32'(cap), 32'(wb));
      check(got_n == n0 + 2 && got[n0] == wc && got[n0+1] == wd, "R10",
            32'({got[n0], got[n0+1]}), 32'({wc, wd}));
      check(int'(err_cnt_o) == e0, "R10", 32'(err_cnt_o), 32'(e0));

      // R7 overrun keeps the older word
      check(!rx_overrun_o, "R7", 32'(rx_overrun_o), 32'd0);
      auto_pop = 1'b0;
      load(8'h01);
      frame(8'hAB, 8'h01, 1'b0, "R7", "R3");
      load(8'h02);
      frame(8'hCD, 8'h02, 1'b0, "R7", "R3");
      check(rx_valid_o && rx_word_o == 8'hAB, "R7", 32'(rx_word_o), 32'hAB);
      check(rx_overrun_o, "R7", 32'(rx_overrun_o), 32'd1);
      auto_pop = 1'b1;
      bit_cyc(1'b0, 1'b0, 1'b0);
      bit_cyc(1'b0, 1'b0, 1'b0);
      check(!rx_valid_o, "R7", 32'(rx_valid_o), 32'd0);

      // Random frames in both modes
      for (int k = 0; k < 40; k++) begin
         logic [W-1:0] rw, tw;
         bit do_ld;
         long_mode = ($urandom % 2) != 0;
         bit_cyc(1'b0, 1'b0, 1'b0);
         rw = W'($urandom);
         tw = W'($urandom);
         do_ld = ($urandom % 5) != 0;
         if (do_ld) load(tw);
         frame(rw, do_ld ? tw : ones_word(), 1'b1,
               long_mode ? "R4" : "R2", long_mode ? "R5" : "R3");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule